// File: doc/BRIEF.md
# PHY Indirect Register Handshake Responder

This block sits on the PHY side of an indirect register path. A host cannot address the PHY's 16-bit registers directly. It drives a 32-bit control word instead and watches a 32-bit status word. Four strobe bits in the control word each mark one phase of an access: capture the address, capture the data, commit a write, or fetch a read. The responder latches the address and data from the low half of the control word on the rising edges of their own strobes. It then writes to or reads from a small file of 16-bit registers.

Every strobe is acknowledged with a four-phase handshake. The acknowledge bit in the status word goes high once a strobe has been held high for a set number of cycles. It goes low again once all strobes have been low for the same number of cycles. Read data stays in the low half of the status word until the next fetch. The register file holds a set of general-purpose scratch registers, a receive override register and a read-only receive status register. Two bits of the override register drive the force outputs for the receiver data path and the receiver PLL.

Top module: `phy_reg_responder`

## Requirements
- R1: During and right after reset, the status word is all zero, both force outputs are low, and every register reads zero.
- R2: The address is taken from control bits 15:0 only at a clock edge where control bit 16 is high and was low at the previous edge. Changing bits 15:0 while bit 16 stays high does not change the latched address.
- R3: The data is taken from control bits 15:0 only on a rising edge of control bit 17. Changing bits 15:0 while bit 17 stays high does not change the latched data.
- R4: On a rising edge of control bit 18, the latched data is written to the latched address if that address is a writable register. Writable registers are the NUM_SCRATCH scratch registers at SCRATCH_BASE+i and the override register at 0x1005.
- R5: On a rising edge of control bit 19, the latched address is read, and the value appears on status bits 15:0 after that edge. It is held there until the next rising edge of bit 19.
- R6: Status bit 16 (ack) rises after the ACK_DELAY-th consecutive clock edge at which any of control bits 19:16 is sampled high. Once high, it stays high while any strobe is high.
- R7: Ack falls after the ACK_DELAY-th consecutive clock edge at which control bits 19:16 are all sampled low.
- R8: Bit 5 of the override register (0x1005) drives rxDataEnForce and bit 3 drives rxPllEnForce. Both change only after the edge that commits a write.
- R9: The receive status register at 0x100D reads as 15 zero bits above the level of rxValid sampled at the fetch edge. Writes to it are ignored.
- R10: Reading any address that is not implemented returns zero. Writing to one leaves every implemented register unchanged.
- R11: Status bits 31:17 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Host control word: [15:0] address/data, [16] address capture, [17] data capture, [18] write commit, [19] read fetch |
| rxValid | input | 1 | Receiver valid flag, sampled at a read fetch of 0x100D |
| statWord | output | 32 | Status word: [15:0] read data, [16] ack, rest zero |
| rxDataEnForce | output | 1 | Override bit 5: force receiver data enable |
| rxPllEnForce | output | 1 | Override bit 3: force receiver PLL enable |

## Verification
Address capture, data capture, write commit and read fetch all act at the first clock edge that sees their strobe high. A read value or a force output is therefore visible at the falling edge that follows, and the bench samples it there. With the default ACK_DELAY of 2, ack is still low at the first falling edge after a strobe is driven and high at the second. The same holds on release. The bench checks both of those falling edges directly. For all other accesses it waits for the ack level before it moves to the next phase, so every read value is taken while the handshake holds it stable.

// File: rtl/phyhs_pkg.sv
package phyhs_pkg;
  localparam int FIELD_W      = 16;
  localparam int BIT_CAP_ADDR = 16;
  localparam int BIT_CAP_DATA = 17;
  localparam int BIT_COMMIT   = 18;
  localparam int BIT_FETCH    = 19;
  localparam int ACK_BIT      = 16;

  localparam logic [FIELD_W-1:0] ADDR_RX_OVRD = 16'h1005;
  localparam logic [FIELD_W-1:0] ADDR_RX_STAT = 16'h100D;
  localparam int OVRD_DATA_EN_BIT = 5;
  localparam int OVRD_PLL_EN_BIT  = 3;

  typedef struct packed {
    logic capAddr;
    logic capData;
    logic commit;
    logic fetch;
  } hsStrobe_t;
endpackage

// File: rtl/phyhs_ctrl.sv
module phyhs_ctrl
  import phyhs_pkg::*;
#(
  parameter int ACK_DELAY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] strobeBits,  // {fetch, commit, capData, capAddr}
  output hsStrobe_t  stb,
  output logic       ackOut
);
  localparam int CNT_W = (ACK_DELAY < 2) ? 1 : $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 1);

  logic [3:0]       prevQ;
  logic [3:0]       riseVec;
  logic             anyHigh;
  logic             ackQ;
  logic [CNT_W-1:0] cntQ;

  assign riseVec = strobeBits & ~prevQ;
  assign anyHigh = |strobeBits;

  always_comb begin
    stb.capAddr = riseVec[0];
    stb.capData = riseVec[1];
    stb.commit  = riseVec[2];
    stb.fetch   = riseVec[3];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= '0;
      ackQ  <= 1'b0;
      cntQ  <= '0;
    end else begin
      prevQ <= strobeBits;
      if (anyHigh == ackQ) begin
        cntQ <= '0;
      end else if (cntQ == CNT_LAST) begin
        ackQ <= anyHigh;
        cntQ <= '0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign ackOut = ackQ;
endmodule

// File: rtl/phyhs_dpath.sv
module phyhs_dpath
  import phyhs_pkg::*;
#(
  parameter int                 NUM_SCRATCH  = 4,
  parameter logic [FIELD_W-1:0] SCRATCH_BASE = 16'h1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] field,
  input  hsStrobe_t          stb,
  input  logic               rxValid,
  output logic [FIELD_W-1:0] rdData,
  output logic               dataEnForce,
  output logic               pllEnForce
);
  logic [FIELD_W-1:0] addrQ;
  logic [FIELD_W-1:0] dataQ;
  logic [FIELD_W-1:0] ovrdQ;
  logic [FIELD_W-1:0] rdQ;
  logic [FIELD_W-1:0] scrOr [NUM_SCRATCH+1];
  logic [FIELD_W-1:0] muxVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (stb.capAddr) addrQ <= field;
      if (stb.capData) dataQ <= field;
    end
  end

  assign scrOr[0] = '0;

  for (genvar i = 0; i < NUM_SCRATCH; i++) begin : gScr
    logic [FIELD_W-1:0] valQ;
    logic               hit;
    assign hit = (addrQ == FIELD_W'(SCRATCH_BASE + i));
    always_ff @(posedge clk) begin
      if (!rstN)                  valQ <= '0;
      else if (stb.commit && hit) valQ <= dataQ;
    end
    assign scrOr[i+1] = scrOr[i] | (hit ? valQ : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                    ovrdQ <= '0;
    else if (stb.commit && addrQ == ADDR_RX_OVRD) ovrdQ <= dataQ;
  end

  always_comb begin
    muxVal = scrOr[NUM_SCRATCH];
    if (addrQ == ADDR_RX_OVRD) muxVal = muxVal | ovrdQ;
    if (addrQ == ADDR_RX_STAT) muxVal = muxVal | {{(FIELD_W-1){1'b0}}, rxValid};
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdQ <= '0;
    else if (stb.fetch) rdQ <= muxVal;
  end

  assign rdData      = rdQ;
  assign dataEnForce = ovrdQ[OVRD_DATA_EN_BIT];
  assign pllEnForce  = ovrdQ[OVRD_PLL_EN_BIT];
endmodule

// File: rtl/phy_reg_responder.sv
module phy_reg_responder
  import phyhs_pkg::*;
#(
  parameter int                 ACK_DELAY    = 2,
  parameter int                 NUM_SCRATCH  = 4,
  parameter logic [FIELD_W-1:0] SCRATCH_BASE = 16'h1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] ctrlWord,
  input  logic        rxValid,
  output logic [31:0] statWord,
  output logic        rxDataEnForce,
  output logic        rxPllEnForce
);
  hsStrobe_t          stb;
  logic               ack;
  logic [FIELD_W-1:0] rdData;
  logic               unusedHi;

  assign unusedHi = ^ctrlWord[31:20];

  phyhs_ctrl #(.ACK_DELAY(ACK_DELAY)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .strobeBits(ctrlWord[BIT_FETCH:BIT_CAP_ADDR]),
    .stb       (stb),
    .ackOut    (ack)
  );

  phyhs_dpath #(.NUM_SCRATCH(NUM_SCRATCH), .SCRATCH_BASE(SCRATCH_BASE)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .field      (ctrlWord[FIELD_W-1:0]),
    .stb        (stb),
    .rxValid    (rxValid),
    .rdData     (rdData),
    .dataEnForce(rxDataEnForce),
    .pllEnForce (rxPllEnForce)
  );

  assign statWord = {15'b0, ack, rdData};
endmodule

// File: rtl/phyhs_checker.sv
module phyhs_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] ctrlWord,
  input logic [31:0] statWord,
  input logic        rxDataEnForce,
  input logic        rxPllEnForce
);
  logic prevCommit, prevFetch;
  logic commitRise, fetchRise, anyStrobe;
  logic unusedCk;

  assign unusedCk = ^{ctrlWord[31:20], ctrlWord[15:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCommit <= 1'b0;
      prevFetch  <= 1'b0;
    end else begin
      prevCommit <= ctrlWord[18];
      prevFetch  <= ctrlWord[19];
    end
  end

  assign commitRise = ctrlWord[18] & ~prevCommit;
  assign fetchRise  = ctrlWord[19] & ~prevFetch;
  assign anyStrobe  = |ctrlWord[19:16];

  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    statWord[31:17] == 15'b0);

  a_r6_ack_rise_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statWord[16]) |-> $past(anyStrobe));

  a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rstN)
    (statWord[16] && anyStrobe) |=> statWord[16]);

  a_r7_ack_fall_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statWord[16]) |-> !$past(anyStrobe));

  a_r5_read_held: assert property (@(posedge clk) disable iff (!rstN)
    !fetchRise |=> $stable(statWord[15:0]));

  a_r8_force_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !commitRise |=> ($stable(rxDataEnForce) && $stable(rxPllEnForce)));
endmodule

bind phy_reg_responder phyhs_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ctrlWord     (ctrlWord),
  .statWord     (statWord),
  .rxDataEnForce(rxDataEnForce),
  .rxPllEnForce (rxPllEnForce)
);

// File: tb/sim_phy_reg_responder.sv
module sim_phy_reg_responder;
  localparam int          NS   = 4;
  localparam logic [15:0] BASE = 16'h1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic        rxValid = 1'b0;
  logic [31:0] statWord;
  logic        rxDataEnForce, rxPllEnForce;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic [15:0] mScr [NS];
  logic [15:0] mOvr;

  always #5 clk = ~clk;

  phy_reg_responder #(.ACK_DELAY(2), .NUM_SCRATCH(NS), .SCRATCH_BASE(BASE)) u0 (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .rxValid(rxValid),
    .statWord(statWord), .rxDataEnForce(rxDataEnForce), .rxPllEnForce(rxPllEnForce));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(logic [15:0] a, logic v);
    if (a >= BASE && a < BASE + NS) return mScr[a - BASE];
    if (a == 16'h1005) return mOvr;
    if (a == 16'h100D) return {15'b0, v};
    return 16'h0;
  endfunction

  function automatic void modelWrite(logic [15:0] a, logic [15:0] d);
    if (a >= BASE && a < BASE + NS) mScr[a - BASE] = d;
    else if (a == 16'h1005) mOvr = d;
  endfunction

  task automatic waitAck(logic v, string req);
    int n = 0;
    while (statWord[16] !== v && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (statWord[16] !== v) check(req, {31'b0, statWord[16]}, {31'b0, v});
  endtask

  task automatic phase(int bitIdx, logic [15:0] low);
    @(negedge clk);
    ctrlWord = {16'b0, low};
    @(negedge clk);
    ctrlWord[bitIdx] = 1'b1;
    waitAck(1'b1, "R6");
    @(negedge clk);
    ctrlWord[bitIdx] = 1'b0;
    waitAck(1'b0, "R7");
  endtask

  task automatic doWrite(logic [15:0] a, logic [15:0] d);
    phase(16, a);
    phase(17, d);
    phase(18, 16'h0);
    modelWrite(a, d);
  endtask

  task automatic doRead(logic [15:0] a, output logic [31:0] st);
    phase(16, a);
    phase(19, 16'h0);
    st = statWord;
  endtask

  task automatic readCheck(logic [15:0] a, string req);
    logic [31:0] st;
    doRead(a, st);
    check(req, st[15:0], {16'b0, expRead(a, rxValid)});
    check("R11", {17'b0, st[31:17]}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] st;
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int i = 0; i < NS; i++) mScr[i] = '0;
    mOvr = '0;

    // R1: state while held in reset and just after release
    repeat (3) @(negedge clk);
    check("R1", statWord, 32'h0);
    check("R1", {30'b0, rxDataEnForce, rxPllEnForce}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", statWord, 32'h0);
    for (int i = 0; i < NS; i++) readCheck(BASE + 16'(i), "R1");
    readCheck(16'h1005, "R1");

    // R6/R7: exact ack timing with ACK_DELAY=2
    @(negedge clk);
    ctrlWord = 32'h0001_1000;
    @(negedge clk);
    check("R6", {31'b0, statWord[16]}, 32'h0);
    @(negedge clk);
    check("R6", {31'b0, statWord[16]}, 32'h1);
    ctrlWord = 32'h0000_1000;
    @(negedge clk);
    check("R7", {31'b0, statWord[16]}, 32'h1);
    @(negedge clk);
    check("R7", {31'b0, statWord[16]}, 32'h0);
    // R6: a strobe shorter than ACK_DELAY produces no ack
    ctrlWord = 32'h0002_0000;
    @(negedge clk);
    ctrlWord = 32'h0;
    @(negedge clk);
    check("R6", {31'b0, statWord[16]}, 32'h0);
    @(negedge clk);
    check("R6", {31'b0, statWord[16]}, 32'h0);

    // R4: scratch registers
    for (int i = 0; i < NS; i++) doWrite(BASE + 16'(i), 16'hA5A0 + 16'(i));
    for (int i = 0; i < NS; i++) readCheck(BASE + 16'(i), "R4");

    // R8: override force bits
    doWrite(16'h1005, 16'h0028);
    check("R8", {30'b0, rxDataEnForce, rxPllEnForce}, 32'h3);
    doWrite(16'h1005, 16'h0020);
    check("R8", {30'b0, rxDataEnForce, rxPllEnForce}, 32'h2);
    doWrite(16'h1005, 16'hFFD7);
    check("R8", {30'b0, rxDataEnForce, rxPllEnForce}, 32'h0);
    doWrite(16'h1005, 16'h0008);
    check("R8", {30'b0, rxDataEnForce, rxPllEnForce}, 32'h1);
    readCheck(16'h1005, "R8");

    // R9: read-only status, valid sampled at fetch
    rxValid = 1'b1;
    readCheck(16'h100D, "R9");
    doWrite(16'h100D, 16'hFFFF);
    rxValid = 1'b0;
    readCheck(16'h100D, "R9");
    rxValid = 1'b1;
    readCheck(16'h100D, "R9");
    // R5: value held after rxValid changes
    rxValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R5", {16'b0, statWord[15:0]}, 32'h1);

    // R10: unimplemented addresses
    doWrite(16'h0000, 16'h2222);
    doWrite(16'hFFFF, 16'h3333);
    doWrite(BASE + 16'(NS), 16'h4444);
    readCheck(16'h0000, "R10");
    readCheck(16'hFFFF, "R10");
    readCheck(BASE + 16'(NS), "R10");
    for (int i = 0; i < NS; i++) readCheck(BASE + 16'(i), "R10");
    readCheck(16'h1005, "R10");
    check("R10", {30'b0, rxDataEnForce, rxPllEnForce}, 32'h1);

    // R2: address only on rising edge of bit 16
    @(negedge clk);
    ctrlWord = 32'h0000_1001;
    @(negedge clk);
    ctrlWord = 32'h0001_1001;
    @(negedge clk);
    ctrlWord = 32'h0001_1002;
    waitAck(1'b1, "R6");
    @(negedge clk);
    ctrlWord = 32'h0;
    waitAck(1'b0, "R7");
    phase(19, 16'h0);
    check("R2", {16'b0, statWord[15:0]}, {16'b0, mScr[1]});

    // R3: data only on rising edge of bit 17
    phase(16, BASE + 16'd2);
    @(negedge clk);
    ctrlWord = 32'h0002_BEEF;
    @(negedge clk);
    ctrlWord = 32'h0002_DEAD;
    waitAck(1'b1, "R6");
    @(negedge clk);
    ctrlWord = 32'h0;
    waitAck(1'b0, "R7");
    phase(18, 16'h0);
    modelWrite(BASE + 16'd2, 16'hBEEF);
    readCheck(BASE + 16'd2, "R3");

    // Random mix of writes and reads
    for (int k = 0; k < 250; k++) begin
      logic [15:0] a;
      int sel;
      sel = int'($urandom % 6);
      case (sel)
        0, 1: a = BASE + 16'($urandom % NS);
        2:    a = 16'h1005;
        3:    a = 16'h100D;
        default: a = 16'($urandom);
      endcase
      rxValid = 1'($urandom);
      if ($urandom % 2 == 0) doWrite(a, 16'($urandom));
      else readCheck(a, "R4");
      check("R8", {30'b0, rxDataEnForce, rxPllEnForce},
            {30'b0, mOvr[5], mOvr[3]});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule